// File: doc/BRIEF.md
# I2C Master Command Engine

This block is a single-message I2C master sequencer driven by a command word and two FIFOs. A write of the command word with its start bit set, while the engine is idle, launches one transaction. The engine issues a start condition, pops the address entry from the transmit FIFO and shifts it out. It then runs one of two protocols. In block write it pops and sends data entries until it reaches one tagged as final. In block read it collects the number of bytes given in the command word and pushes each into the receive FIFO.

On completion, the busy bit in the command readback clears and a 3-bit outcome code tells software what happened. The outcome separates a refused address, a refused data byte, lost arbitration and a bus held low for too long. SCL and SDA are open-drain: the `_oe` outputs pull a line low when high, and the `_i` inputs return the resolved line level. The bit rate is picked by a single mode input and derived from the fixed system clock frequency. Each bit is built from four equal quarter-periods.

Top module: `i2c_cmd_engine`

## Requirements
- R1: Writing `cmd_wdata` with bit 31 set while idle starts a transaction. From the next cycle, `cmd_rdata` bit 31 reads 1 until the transaction ends. `cmd_rdata` shows the protocol in bits 12:9, the read count in bits 7:0 and the outcome in bits 27:25. All other bits read 0, and the outcome stays constant while idle.
- R2: With protocol 7 (block write), the engine first sends the transmit entry's bits 7:0 as the address byte (7-bit address shifted left by one, R/W in bit 0). It then sends the bits 7:0 of each later entry in FIFO order. It issues a stop after the entry whose bit 31 is 1 and reports outcome 0. SDA changes only while SCL is low, except for start and stop.
- R3: With protocol 8 (block read), the engine pushes exactly the commanded number of received bytes into the receive FIFO (`rx_data` bits 7:0), in bus order, and reports outcome 0.
- R4: During a block read, the engine acknowledges every received byte except the last, which it answers with a NACK before the stop.
- R5: A NACK on the address byte ends the transaction with a stop. The outcome is 2, and no data byte is sent or received.
- R6: A NACK on a written data byte ends the transaction with a stop after that byte, with outcome 3.
- R7: If the engine releases SDA and sees it low while SCL is high during an address or write-data bit, it releases both lines at once and reports outcome 1.
- R8: If SCL stays low after the engine has released it for more than `scl_timeout` cycles, the engine aborts, releases the bus and reports outcome 4.
- R9: A target holding SCL low for fewer than `scl_timeout` cycles only delays the transfer, which then completes normally.
- R10: With `fast_mode` = 1 the SCL period is CLK_HZ/400000 cycles; with `fast_mode` = 0 it is CLK_HZ/100000 cycles.
- R11: A command write while busy is ignored. The running transaction, its protocol and its count fields are unchanged.
- R12: After reset and whenever idle, both bus lines are released, and `cmd_rdata` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: bit 31 start, 12:9 protocol, 7:0 read count |
| cmd_rdata | output | 32 | Readback: bit 31 busy, 27:25 outcome, 12:9 protocol, 7:0 count |
| fast_mode | input | 1 | 1 selects 400 kHz, 0 selects 100 kHz |
| scl_timeout | input | TW | Allowed cycles of SCL held low by another device |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | 32 | Transmit FIFO head: bits 7:0 byte, bit 31 final-byte tag |
| tx_pop | output | 1 | Consume transmit FIFO head |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_data | output | 8 | Received byte |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench builds the engine with CLK_HZ set to 1.6 MHz. This makes a quarter bit four cycles in standard mode and one cycle in fast mode, so whole multi-byte transactions in both speeds fit in a few hundred cycles. It also exposes the single-cycle quarter, where SDA hold and sampling are tightest. `scl_timeout` is driven to 40, so a 20-cycle stretch lands inside the limit and an unbounded hold lands beyond it, and both the tolerated and the aborting paths are reached.

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine #(
  parameter int CLK_HZ = 100_000_000,
  parameter int TW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [31:0]   cmd_wdata,
  output logic [31:0]   cmd_rdata,
  input  logic          fast_mode,
  input  logic [TW-1:0] scl_timeout,
  input  logic          tx_valid,
  input  logic [31:0]   tx_data,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [7:0]    rx_data,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int Q_SLOW = (CLK_HZ / 400_000 > 0) ? CLK_HZ / 400_000 : 1;
  localparam int Q_FAST = (CLK_HZ / 1_600_000 > 0) ? CLK_HZ / 1_600_000 : 1;
  localparam int QW     = $clog2(Q_SLOW + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} st_t;

  st_t           st;
  logic [1:0]    ph;
  logic [QW-1:0] qcnt;
  logic [3:0]    idx;
  logic [7:0]    sh, rcnt, cnt_r;
  logic [3:0]    proto;
  logic [2:0]    status;
  logic [TW-1:0] tcnt;
  logic          is_addr, rd_mode, last_b, samp, sda_hold, sda_want;

  wire unused_fields = ^{tx_data[30:8], cmd_wdata[30:13], cmd_wdata[8]};

  wire           busy   = (st != S_IDLE);
  wire           launch = cmd_wr && cmd_wdata[31] && !busy;
  wire [QW-1:0]  qlim   = fast_mode ? QW'(Q_FAST - 1) : QW'(Q_SLOW - 1);
  wire           stall  = busy && (ph == 2'd2) && !scl_i;
  wire           tick   = busy && !stall && (qcnt == qlim);
  wire           xmit   = is_addr || !rd_mode;
  wire           lost   = (st == S_BYTE) && (idx != 4'd8) && xmit && sh[7] && ph[1] && scl_i && !sda_i;
  wire           tmo    = stall && (tcnt >= scl_timeout);
  wire           ack_end = tick && (st == S_BYTE) && (idx == 4'd8) && (ph == 2'd3);

  assign cmd_rdata = {busy, 3'b000, status, 12'd0, proto, 1'b0, cnt_r};
  assign scl_oe    = ((st == S_BYTE) || (st == S_STOP)) && !ph[1];
  assign sda_oe    = (((st == S_BYTE) || (st == S_STOP)) && (ph == 2'd0)) ? sda_hold : sda_want;
  assign rx_push   = ack_end && !xmit;
  assign rx_data   = sh;
  assign tx_pop    = (tick && (st == S_START) && (ph == 2'd3) && tx_valid) ||
                     (ack_end && xmit && !samp && !rd_mode && tx_valid && (is_addr || !last_b));

  always_comb begin
    unique case (st)
      S_START: sda_want = ph[1];
      S_STOP:  sda_want = (ph != 2'd3);
      S_BYTE:  sda_want = (idx == 4'd8) ? (!xmit && (rcnt != 8'd1)) : (xmit && !sh[7]);
      default: sda_want = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; qcnt <= '0; idx <= '0; sh <= '0; rcnt <= '0;
      cnt_r <= '0; proto <= '0; status <= '0; tcnt <= '0; is_addr <= 1'b0;
      rd_mode <= 1'b0; last_b <= 1'b0; samp <= 1'b0; sda_hold <= 1'b0;
    end else begin
      sda_hold <= sda_oe;
      if (launch) begin
        st <= S_START; ph <= '0; qcnt <= '0; tcnt <= '0; status <= '0;
        proto <= cmd_wdata[12:9]; cnt_r <= cmd_wdata[7:0]; rcnt <= cmd_wdata[7:0];
        rd_mode <= (cmd_wdata[12:9] == 4'd8);
      end else if (busy) begin
        tcnt <= stall ? tcnt + TW'(1) : '0;
        if (lost) begin
          st <= S_IDLE; status <= 3'd1;
        end else if (tmo) begin
          st <= S_IDLE; status <= 3'd4;
        end else if (!stall) begin
          if (qcnt != qlim) qcnt <= qcnt + QW'(1);
          else begin
            qcnt <= '0;
            ph   <= ph + 2'd1;
            if (ph == 2'd2) samp <= sda_i;
            if (ph == 2'd3) begin
              unique case (st)
                S_START: begin
                  st <= S_BYTE; idx <= '0; is_addr <= 1'b1; sh <= tx_data[7:0];
                end
                S_BYTE: begin
                  if (idx != 4'd8) begin
                    idx <= idx + 4'd1;
                    sh  <= {sh[6:0], samp};
                  end else begin
                    idx <= '0;
                    if (xmit && samp) begin
                      status <= is_addr ? 3'd2 : 3'd3;
                      st     <= S_STOP;
                    end else if (is_addr) begin
                      is_addr <= 1'b0;
                      if (rd_mode) begin
                        if (rcnt == 8'd0) st <= S_STOP;
                      end else if (tx_valid) begin
                        sh <= tx_data[7:0]; last_b <= tx_data[31];
                      end else st <= S_STOP;
                    end else if (rd_mode) begin
                      rcnt <= rcnt - 8'd1;
                      if (rcnt == 8'd1) st <= S_STOP;
                    end else if (last_b || !tx_valid) st <= S_STOP;
                    else begin
                      sh <= tx_data[7:0]; last_b <= tx_data[31];
                    end
                  end
                end
                S_STOP:  st <= S_IDLE;
                default: st <= S_IDLE;
              endcase
            end
          end
        end
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R12
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |=> $stable(status)); // R1
  AST_POP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> busy); // R2
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_BYTE) && !$stable(sda_oe)) |-> scl_oe); // R2
  AST_PUSH_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (busy && rd_mode)); // R3
  AST_LOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (!scl_oe && !sda_oe && status == 3'd1)); // R7
  AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (!busy && status == 3'd4)); // R8
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ({proto, cnt_r} == $past({proto, cnt_r}))); // R11
endmodule

// File: tb/i2c_cmd_engine_tb.sv
module i2c_cmd_engine_tb;
  localparam int CLK_HZ = 1_600_000;
  localparam int TW = 16;
  localparam logic [6:0] SLV = 7'h50;
  // [31] read, [30] fast, [29] wrong address, [23:16] length, [15:8] nack index (FF none), [2:0] outcome
  localparam logic [31:0] VEC [8] = '{
    32'h0003FF00, 32'h8004FF00, 32'h4005FF00, 32'hC001FF00,
    32'h2002FF02, 32'hE003FF02, 32'h40040103, 32'h0001FF00};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cmd_wr = 1'b0, fast_mode = 1'b0, tx_flush = 1'b0;
  logic hold_scl = 1'b0, arb_force = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [TW-1:0] scl_timeout = TW'(40);
  logic [31:0] cmd_rdata, tx_data;
  logic tx_valid, tx_pop, rx_push, scl_i, sda_i, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic slv_sda_low = 1'b0;

  i2c_cmd_engine #(.CLK_HZ(CLK_HZ), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .fast_mode(fast_mode), .scl_timeout(scl_timeout), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  assign scl_i = !(scl_oe || hold_scl);
  assign sda_i = !(sda_oe || slv_sda_low || arb_force);

  logic [31:0] txq [0:511];
  logic [7:0]  rxq [0:511];
  int tx_wp = 0, tx_rp = 0, rx_n = 0, rx_before = 0, cyc = 0, last_rise = 0, period = 0;
  logic pscl_m = 1'b1;
  assign tx_valid = tx_rp < tx_wp;
  assign tx_data  = txq[tx_rp[8:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_flush) tx_rp <= tx_wp;
    else if (tx_pop) tx_rp <= tx_rp + 1;
    if (rx_push) begin rxq[rx_n[8:0]] <= rx_data; rx_n <= rx_n + 1; end
  end

  always @(negedge clk) begin
    if (!pscl_m && scl_i) begin period = cyc - last_rise; last_rise = cyc; end
    pscl_m = scl_i;
  end

  function automatic logic [7:0] rdbyte(int i); return 8'hC3 ^ 8'(i * 29); endfunction
  function automatic logic [7:0] wbyte(int v, int i); return 8'h3C + 8'(i * 23) + 8'(v * 5); endfunction

  // behavioural target
  logic pscl = 1'b1, psda = 1'b1, active = 1'b0, s_addr = 1'b0, sending = 1'b0;
  logic addr_ok = 1'b0, rw = 1'b0, mack = 1'b0;
  logic [3:0] nb = '0;
  logic [7:0] shr = '0, txb = '0;
  logic [7:0] wbuf [0:63];
  int wcnt = 0, acks = 0, nacks = 0, rdi = 0, nack_at_cfg = 255;

  always @(negedge clk) begin
    if (pscl && scl_i && psda && !sda_i) begin
      active = 1'b1; nb = '0; s_addr = 1'b1; sending = 1'b0; slv_sda_low = 1'b0;
      wcnt = 0; acks = 0; nacks = 0; rdi = 0;
    end else if (pscl && scl_i && !psda && sda_i) begin
      active = 1'b0; slv_sda_low = 1'b0; sending = 1'b0;
    end else if (active && !pscl && scl_i) begin
      if (nb < 4'd8) shr = {shr[6:0], sda_i}; else mack = sda_i;
      nb = nb + 4'd1;
    end else if (active && pscl && !scl_i) begin
      if (nb == 4'd8) begin
        if (sending) slv_sda_low = 1'b0;
        else if (s_addr) begin addr_ok = (shr[7:1] == SLV); rw = shr[0]; slv_sda_low = addr_ok; end
        else begin
          if (wcnt < 64) wbuf[wcnt] = shr;
          slv_sda_low = (wcnt != nack_at_cfg);
          wcnt = wcnt + 1;
        end
      end else if (nb == 4'd9) begin
        nb = '0; slv_sda_low = 1'b0;
        if (s_addr) begin s_addr = 1'b0; sending = addr_ok && rw; end
        else if (sending) begin
          if (!mack) acks = acks + 1; else begin nacks = nacks + 1; sending = 1'b0; end
        end
        if (sending) begin txb = rdbyte(rdi); rdi = rdi + 1; slv_sda_low = !txb[7]; end
      end else if (sending && nb >= 4'd1 && nb <= 4'd7) slv_sda_low = !txb[3'(4'd7 - nb)];
    end
    pscl = scl_i; psda = sda_i;
  end

  int nchk = 0, nfail = 0;
  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_txn(input bit rd, input bit fast, input logic [6:0] a, input int n, input int v);
    fast_mode = fast;
    @(negedge clk) tx_flush = 1'b1;
    @(negedge clk) tx_flush = 1'b0;
    txq[tx_wp[8:0]] = {24'd0, a, rd}; tx_wp++;
    if (!rd) for (int i = 0; i < n; i++) begin
      txq[tx_wp[8:0]] = {(i == n - 1), 23'd0, wbyte(v, i)}; tx_wp++;
    end
    rx_before = rx_n;
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = {1'b1, 18'd0, rd ? 4'd8 : 4'd7, 1'b0, 8'(n)};
    @(negedge clk) cmd_wr = 1'b0;
    check("R1 busy after launch", int'(cmd_rdata[31]), 1);
    check("R1 protocol field", int'(cmd_rdata[12:9]), rd ? 8 : 7);
  endtask

  task automatic wait_done(output int dur);
    dur = 0;
    while (cmd_rdata[31] && dur < 20000) begin @(negedge clk); dur++; end
    check("R1 busy clears", int'(cmd_rdata[31]), 0);
    check("R12 bus released when idle", int'({scl_oe, sda_oe}), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int dur;
    repeat (5) @(negedge clk);
    check("R12 reset readback", int'(cmd_rdata), 0);
    check("R12 reset bus released", int'({scl_oe, sda_oe, tx_pop, rx_push}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      automatic bit rd = VEC[v][31];
      automatic bit fast = VEC[v][30];
      automatic int n = int'(VEC[v][23:16]);
      automatic int exp = int'(VEC[v][2:0]);
      nack_at_cfg = int'(VEC[v][15:8]);
      start_txn(rd, fast, VEC[v][29] ? (SLV ^ 7'h01) : SLV, n, v);
      wait_done(dur);
      check("R1 outcome", int'(cmd_rdata[27:25]), exp);
      check("R10 SCL period", period, fast ? CLK_HZ / 400_000 : CLK_HZ / 100_000);
      if (exp == 0 && !rd) begin
        check("R2 bytes written", wcnt, n);
        for (int i = 0; i < n; i++) check("R2 write data", int'(wbuf[i]), int'(wbyte(v, i)));
      end
      if (exp == 0 && rd) begin
        check("R3 bytes read", rx_n - rx_before, n);
        for (int i = 0; i < n; i++) check("R3 read data", int'(rxq[(rx_before + i) % 512]), int'(rdbyte(i)));
        check("R4 acked bytes", acks, n - 1);
        check("R4 final nack", nacks, 1);
      end
      if (exp == 2) begin
        check("R5 no data written", wcnt, 0);
        check("R5 no data read", rx_n - rx_before, 0);
      end
      if (exp == 3) check("R6 stop after nacked byte", wcnt, nack_at_cfg + 1);
    end
    nack_at_cfg = 255;

    // R11: command while busy is ignored
    start_txn(1'b1, 1'b0, SLV, 2, 0);
    repeat (4) @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = {1'b1, 18'd0, 4'd7, 1'b0, 8'd9};
    @(negedge clk) cmd_wr = 1'b0;
    @(negedge clk);
    check("R11 fields unchanged", int'(cmd_rdata[12:0]), int'({4'd8, 1'b0, 8'd2}));
    check("R11 still busy", int'(cmd_rdata[31]), 1);
    wait_done(dur);
    check("R11 original read completes", rx_n - rx_before, 2);
    check("R11 outcome", int'(cmd_rdata[27:25]), 0);

    // R9: short stretch tolerated
    start_txn(1'b0, 1'b0, SLV, 2, 9);
    dur = 0;
    while (scl_i && dur < 2000) begin @(negedge clk); dur++; end
    hold_scl = 1'b1;
    repeat (20) @(negedge clk);
    hold_scl = 1'b0;
    wait_done(dur);
    check("R9 outcome after stretch", int'(cmd_rdata[27:25]), 0);
    check("R9 bytes written", wcnt, 2);

    // R8: held SCL times out
    start_txn(1'b0, 1'b0, SLV, 2, 10);
    dur = 0;
    while (scl_i && dur < 2000) begin @(negedge clk); dur++; end
    hold_scl = 1'b1;
    wait_done(dur);
    check("R8 timeout outcome", int'(cmd_rdata[27:25]), 4);
    check("R8 waited past limit", int'(dur > 40), 1);
    hold_scl = 1'b0;
    repeat (4) @(negedge clk);

    // R7: arbitration loss on first address bit (address 0x50 sends 1 first)
    start_txn(1'b0, 1'b1, SLV, 2, 11);
    dur = 0;
    while (scl_i && dur < 2000) begin @(negedge clk); dur++; end
    arb_force = 1'b1;
    wait_done(dur);
    check("R7 arbitration outcome", int'(cmd_rdata[27:25]), 1);
    check("R7 prompt release", int'(dur < 10), 1);
    arb_force = 1'b0;
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule